// File: doc/BRIEF.md
# Block Readiness Handshake Controller

This controller sits at the input of a block-mode decoder. It frames the incoming stream into blocks and tells the data source when a new block may begin. The source marks each block with two single-cycle strobes, one for the first sample and one for the last. The controller answers with a ready output. After a block has closed, the next start strobe is only legal once ready is high. A start strobe that breaks this rule sets a sticky error flag and is otherwise ignored.

The `DYN_MODE` parameter picks one of two timing variants.

- **Fixed-puncturing zero-flush variant (`DYN_MODE=0`).** A phase counter starts at each accepted start. It marks the last cycle of every window of `TB_LEN` cycles, where `TB_LEN` is the traceback length. Ready is re-asserted only on such a boundary cycle. A block whose length is a whole number of windows can therefore be followed by the next block with no idle cycle in between.
- **Dynamic-puncturing variant (`DYN_MODE=1`).** Ready drops for the whole block. It rises a fixed `POST_DLY` cycles after the end strobe.

Top module: `blk_ready_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, ready_o is 1 and err_o is 0.
- R2: A start strobe is accepted only when ready_o is 1 in that same cycle and no block is open. The cycle that carries the end strobe still counts as inside the block.
- R3: In the cycle after an accepted start, ready_o is 0. It stays 0 while the block is open, except for the case in R4.
- R4: With DYN_MODE=0, cycle s+k*TB_LEN-1 is a boundary for every k>=1, where s is the cycle of the accepted start. An end strobe on a boundary makes ready_o 1 in that same cycle, so a start in the next cycle is accepted.
- R5: With DYN_MODE=0, an end strobe off a boundary keeps ready_o at 0 until the next boundary cycle. From that cycle on, ready_o stays 1 until the next accepted start.
- R6: With DYN_MODE=1, an end strobe in cycle e keeps ready_o at 0 through cycle e+POST_DLY-1. ready_o is 1 from cycle e+POST_DLY on.
- R7: A start strobe that is not accepted has no effect on the block or its phase. From the next cycle on, err_o is 1.
- R8: err_o stays 1 until reset.
- R9: An end strobe while no block is open is ignored. ready_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start_i | input | 1 | Single-cycle strobe on the first cycle of a block |
| blk_end_i | input | 1 | Single-cycle strobe on the last cycle of a block |
| ready_o | output | 1 | A new block may start (see R2 to R6) |
| err_o | output | 1 | Sticky flag: a start arrived when it was not allowed |

## Verification
The bench builds two instances, both with a short window of TB_LEN=4. The first uses DYN_MODE=0. With this short window a single table can reach several cases in a few dozen cycles: a block of exactly one window, a block that ends off a boundary and waits, a block that spans two windows, and a rejected start in the middle of a block. The second instance uses DYN_MODE=1 with POST_DLY=4. On it the bench checks the exact post-end delay, a rejected start, and the clearing of the flag by reset.

// File: rtl/blk_rdy_pkg.sv
package blk_rdy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_DRAIN = 2'd2
  } blk_st_e;

  // true when a count has reached the last value of a window of lim cycles
  function automatic logic hit_last(int unsigned c, int unsigned lim);
    return c == lim - 1;
  endfunction

  // counter wrap value, large enough to hold the drain delay too
  function automatic int unsigned wrap_of(int unsigned dyn, int unsigned tb, int unsigned dly);
    return (dyn != 0) ? dly + 1 : tb;
  endfunction

endpackage

// File: rtl/blk_phase_cnt.sv
module blk_phase_cnt #(
  parameter int unsigned WRAP = 16,
  parameter int unsigned CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LAST = CW'(WRAP - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(1);
    end else if (run) begin
      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end
  end

endmodule

// File: rtl/blk_rdy_fsm.sv
module blk_rdy_fsm
  import blk_rdy_pkg::*;
#(
  parameter bit          DYN_MODE = 1'b0,
  parameter int unsigned TB_LEN   = 16,
  parameter int unsigned POST_DLY = 4,
  parameter int unsigned CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_start_i,
  input  logic          blk_end_i,
  input  logic [CW-1:0] cnt,
  output logic          cnt_load,
  output logic          cnt_run,
  output logic          ready_o,
  output logic          err_o,
  output logic          start_ok,
  output logic          start_bad,
  output logic          end_ok,
  output logic          at_bnd,
  output logic          idle
);

  blk_st_e st, st_nx;
  logic    open_blk, drain;

  assign idle     = (st == ST_IDLE);
  assign open_blk = (st == ST_OPEN);
  assign drain    = (st == ST_DRAIN);

  assign start_ok  = blk_start_i & ready_o & ~open_blk;
  assign start_bad = blk_start_i & ~start_ok;
  assign end_ok    = blk_end_i & open_blk;

  generate
    if (DYN_MODE) begin : g_dyn
      assign at_bnd   = hit_last(int'(cnt), POST_DLY);
      assign ready_o  = idle;
      assign cnt_load = end_ok;
      assign cnt_run  = drain;
      always_comb begin
        st_nx = st;
        case (st)
          ST_IDLE:  if (start_ok) st_nx = ST_OPEN;
          ST_OPEN:  if (end_ok) st_nx = (POST_DLY <= 1) ? ST_IDLE : ST_DRAIN;
          ST_DRAIN: if (at_bnd) st_nx = ST_IDLE;
          default:  st_nx = ST_IDLE;
        endcase
      end
    end else begin : g_fix
      assign at_bnd   = hit_last(int'(cnt), TB_LEN);
      assign ready_o  = idle | (open_blk & at_bnd & blk_end_i) | (drain & at_bnd);
      assign cnt_load = start_ok;
      assign cnt_run  = ~idle;
      always_comb begin
        st_nx = st;
        case (st)
          ST_IDLE:  if (start_ok) st_nx = ST_OPEN;
          ST_OPEN:  if (end_ok) st_nx = at_bnd ? ST_IDLE : ST_DRAIN;
          ST_DRAIN: begin
            if (start_ok)    st_nx = ST_OPEN;
            else if (at_bnd) st_nx = ST_IDLE;
          end
          default:  st_nx = ST_IDLE;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      err_o <= 1'b0;
    end else begin
      st    <= st_nx;
      err_o <= err_o | start_bad;
    end
  end

endmodule

// File: rtl/blk_ready_ctrl.sv
module blk_ready_ctrl
  import blk_rdy_pkg::*;
#(
  parameter bit          DYN_MODE = 1'b0,
  parameter int unsigned TB_LEN   = 16,
  parameter int unsigned POST_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_start_i,
  input  logic blk_end_i,
  output logic ready_o,
  output logic err_o
);

  localparam int unsigned WRAP = wrap_of(DYN_MODE, TB_LEN, POST_DLY);
  localparam int unsigned CW   = (WRAP < 2) ? 1 : $clog2(WRAP);

  logic [CW-1:0] cnt;
  logic          cnt_load, cnt_run;
  logic          start_ok, start_bad, end_ok, at_bnd, idle;

  blk_phase_cnt #(.WRAP(WRAP), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cnt_load),
    .run   (cnt_run),
    .cnt   (cnt)
  );

  blk_rdy_fsm #(
    .DYN_MODE (DYN_MODE),
    .TB_LEN   (TB_LEN),
    .POST_DLY (POST_DLY),
    .CW       (CW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_start_i (blk_start_i),
    .blk_end_i   (blk_end_i),
    .cnt         (cnt),
    .cnt_load    (cnt_load),
    .cnt_run     (cnt_run),
    .ready_o     (ready_o),
    .err_o       (err_o),
    .start_ok    (start_ok),
    .start_bad   (start_bad),
    .end_ok      (end_ok),
    .at_bnd      (at_bnd),
    .idle        (idle)
  );

endmodule

// File: rtl/blk_ready_chk.sv
module blk_ready_chk #(
  parameter bit          DYN_MODE = 1'b0,
  parameter int unsigned POST_DLY = 4
) (
  input logic clk,
  input logic rst_n,
  input logic blk_end_i,
  input logic ready_o,
  input logic err_o,
  input logic start_ok,
  input logic start_bad,
  input logic end_ok,
  input logic at_bnd,
  input logic idle
);

  assert_drop_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (!ready_o || blk_end_i));

  assert_flag_on_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> err_o);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  generate
    if (DYN_MODE) begin : g_dyn
      int unsigned wcnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                                 wcnt <= 0;
        else if (end_ok)                            wcnt <= 1;
        else if (wcnt != 0 && wcnt < POST_DLY)      wcnt <= wcnt + 1;
        else                                        wcnt <= 0;
      end
      assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt != 0 && wcnt < POST_DLY) |-> !ready_o);
      assert_rise_on_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt != 0 && wcnt == POST_DLY) |-> ready_o);
      assert_ready_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> idle);
    end else begin : g_fix
      assert_ready_on_bnd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !idle) |-> at_bnd);
    end
  endgenerate

endmodule

bind blk_ready_ctrl blk_ready_chk #(.DYN_MODE(DYN_MODE), .POST_DLY(POST_DLY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .blk_end_i (blk_end_i),
  .ready_o   (ready_o),
  .err_o     (err_o),
  .start_ok  (start_ok),
  .start_bad (start_bad),
  .end_ok    (end_ok),
  .at_bnd    (at_bnd),
  .idle      (idle)
);

// File: tb/tb_blk_ready_ctrl.sv
module tb_blk_ready_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f_start = 1'b0, f_end = 1'b0, d_start = 1'b0, d_end = 1'b0;
  logic f_rdy, f_err, d_rdy, d_err;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  blk_ready_ctrl #(.DYN_MODE(1'b0), .TB_LEN(4), .POST_DLY(4)) dut (
    .clk(clk), .rst_n(rst_n), .blk_start_i(f_start), .blk_end_i(f_end),
    .ready_o(f_rdy), .err_o(f_err));

  blk_ready_ctrl #(.DYN_MODE(1'b1), .TB_LEN(4), .POST_DLY(4)) dut_dyn (
    .clk(clk), .rst_n(rst_n), .blk_start_i(d_start), .blk_end_i(d_end),
    .ready_o(d_rdy), .err_o(d_err));

  // {start, end, expected ready, expected err} per cycle, fixed variant, window 4
  localparam int NV = 22;
  localparam logic [3:0] VEC [NV] = '{
    4'b0010, // R1 idle after reset
    4'b1010, // R2 start accepted, phase 0
    4'b0000, // R3 low after start
    4'b0000,
    4'b0110, // R4 end on boundary -> ready same cycle
    4'b1010, // R4 back-to-back start accepted
    4'b0000,
    4'b0100, // R5 end off boundary, still low
    4'b0010, // R5 rises on next boundary
    4'b0010, // R5 stays high
    4'b1010, // R2 start
    4'b1000, // R7 start while low: ignored
    4'b0001, // R7 flag set
    4'b0001, // R3 boundary without end stays low
    4'b0001,
    4'b0101, // end off boundary (phase not restarted by R7 start)
    4'b0001,
    4'b0011, // R7 boundary from original start only
    4'b0011, // R8 flag held
    4'b0111, // R9 end while idle ignored
    4'b1011, // R9 start still accepted
    4'b0001  // R3
  };

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%b exp=%b", req, what, got, exp);
    end
  endtask

  task automatic dyn_step(input logic s, input logic e, input logic exp_r, input string req);
    @(negedge clk);
    d_start = s; d_end = e;
    #1;
    chk(d_rdy, exp_r, req, "dyn ready");
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(f_rdy, 1'b1, "R1", "fixed ready in reset");
    chk(f_err, 1'b0, "R1", "fixed err in reset");
    chk(d_rdy, 1'b1, "R1", "dyn ready in reset");
    chk(d_err, 1'b0, "R1", "dyn err in reset");
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      f_start = VEC[i][3];
      f_end   = VEC[i][2];
      #1;
      chk(f_rdy, VEC[i][1], "R4/R5 table", $sformatf("fixed ready row %0d", i));
      chk(f_err, VEC[i][0], "R7/R8 table", $sformatf("fixed err row %0d", i));
    end
    @(negedge clk);
    f_start = 1'b0; f_end = 1'b0;

    // dynamic variant, post-end delay 4
    dyn_step(1'b1, 1'b0, 1'b1, "R2");
    dyn_step(1'b0, 1'b0, 1'b0, "R3");
    dyn_step(1'b0, 1'b0, 1'b0, "R3");
    dyn_step(1'b0, 1'b1, 1'b0, "R6");
    dyn_step(1'b0, 1'b0, 1'b0, "R6");
    dyn_step(1'b0, 1'b0, 1'b0, "R6");
    dyn_step(1'b0, 1'b0, 1'b0, "R6");
    dyn_step(1'b0, 1'b0, 1'b1, "R6");
    dyn_step(1'b1, 1'b0, 1'b1, "R2");
    dyn_step(1'b1, 1'b0, 1'b0, "R7");
    dyn_step(1'b0, 1'b0, 1'b0, "R7");
    chk(d_err, 1'b1, "R7", "dyn err after rejected start");
    dyn_step(1'b0, 1'b1, 1'b0, "R6");
    dyn_step(1'b0, 1'b0, 1'b0, "R6");
    dyn_step(1'b0, 1'b0, 1'b0, "R6");
    dyn_step(1'b0, 1'b0, 1'b0, "R6");
    dyn_step(1'b0, 1'b0, 1'b1, "R6");
    chk(d_err, 1'b1, "R8", "dyn err held");
    dyn_step(1'b0, 1'b0, 1'b1, "R6");

    // reset clears the flags
    @(negedge clk);
    d_start = 1'b0; d_end = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(d_err, 1'b0, "R1", "dyn err after reset");
    chk(f_err, 1'b0, "R1", "fixed err after reset");
    chk(f_rdy, 1'b1, "R1", "fixed ready after reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule